// File: doc/BRIEF.md
# Configurable LUT4 Adder Logic Element Cluster

This block models a row of configurable logic elements for an FPGA fabric. Each element holds a 4-input lookup table, one flip-flop, a carry-select cell and two configuration-driven multiplexers. An element can act as an arbitrary 4-input function. It can also act as one bit of an adder: the lower half of its truth table then serves as two 2-input sub-tables that produce a propagate term and a generate term for the carry cell.

The top module chains `N_ELEM` elements (8 by default) into a ripple-carry row. The cluster carry-in enters element 0. Each element's carry-out feeds the carry-in of the next element, and the last element's carry-out is the cluster carry-out. Configuration uses a plain parallel write: each element has its own enable bit, and all elements share one 18-bit configuration word.

Top module: `lut4_adder_cluster`

## Requirements
- R1: The configuration word holds the truth table in bits 15:0, the LUT-input-2 source select in bit 16 and the output select in bit 17. The truth table is indexed by {in3,in2,in1,in0}. When bit 17 is 0, an element's output is the truth-table bit at that index, combinationally.
- R2: LUT inputs 0, 1 and 3 come from data bits 0, 1 and 3 of the element. LUT input 2 is the element's carry-in when config bit 16 is 1, and data bit 2 when it is 0.
- R3: Each element computes its carry-out as (p ? carry-in : g). Here p is truth-table bit {0,0,in1,in0} and g is truth-table bit {0,1,in1,in0}.
- R4: When config bit 17 is 1, the element output is a flip-flop, loaded on the rising clock edge with the 4-input LUT result. Between edges the output holds its value.
- R5: The active-high reset is synchronous. It clears every flip-flop and every configuration register, so all outputs read 0 afterwards.
- R6: An element's configuration register loads `cfg_word` on a rising edge only when that element's `cfg_en` bit is 1. Otherwise it holds its value.
- R7: `cin` enters element 0, the carry-out of element i drives the carry-in of element i+1, and the carry-out of the last element is `cout`. When every element propagates, `cout` equals `cin`.
- R8: Each element can be configured as a full-adder bit. This uses truth table 16'h9686, select bit 16 set, data bit 3 tied to 1, and the operand bits on data bits 0 and 1. The row then produces the sum a+b+cin on `dout` and the carry on `cout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | N_ELEM | Per-element configuration write enable |
| cfg_word | input | 18 | Configuration word shared by all elements |
| din | input | 4*N_ELEM | Data inputs, 4 bits per element, element i at bits 4i+3:4i |
| cin | input | 1 | Cluster carry-in |
| cout | output | 1 | Cluster carry-out |
| dout | output | N_ELEM | Element outputs, one bit per element |

## Verification
The assertions check the following on every cycle:
- Each configuration register loads only when its enable bit is set, and holds otherwise.
- Reset clears both the configuration and the flip-flops.
- In registered mode, an element's output equals its LUT result from the previous cycle.
- When every element propagates, the carry passes through the whole row unchanged.

Only the bench scenarios can show the following:
- The arithmetic of the full-adder configuration over many operands, including long carry ripples.
- The exact truth-table index mapping.
- The input-2 source selection with the carry-in set opposite to data bit 2.
- That a write to one element leaves the others unchanged.

// File: rtl/lut4_adder_cluster.sv
module lut4_adder_cluster #(
  parameter int N_ELEM = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_ELEM-1:0]     cfg_en,
  input  logic [17:0]           cfg_word,
  input  logic [4*N_ELEM-1:0]   din,
  input  logic                  cin,
  output logic                  cout,
  output logic [N_ELEM-1:0]     dout
);
  localparam int LUT_IN   = 4;
  localparam int LUT_BITS = 1 << LUT_IN;
  localparam int CFG_W    = LUT_BITS + 2;
  localparam int SEL_IN2  = LUT_BITS;
  localparam int SEL_OUT  = LUT_BITS + 1;

  logic [N_ELEM:0]         carry;
  logic [N_ELEM*CFG_W-1:0] cfg_flat;
  logic [N_ELEM-1:0]       lut_f, prop, gen, ffq;

  assign carry[0] = cin;
  assign cout     = carry[N_ELEM];

  for (genvar i = 0; i < N_ELEM; i++) begin : g_elem
    logic [CFG_W-1:0]    cfg;
    logic [LUT_BITS-1:0] tbl;
    logic [LUT_IN-1:0]   d, idx;
    logic                q;

    assign d   = din[i*LUT_IN +: LUT_IN];
    assign tbl = cfg[LUT_BITS-1:0];

    always_ff @(posedge clk) begin
      if (rst)            cfg <= '0;
      else if (cfg_en[i]) cfg <= cfg_word;
    end

    assign idx      = {d[3], (cfg[SEL_IN2] ? carry[i] : d[2]), d[1:0]};
    assign lut_f[i] = tbl[idx];
    assign prop[i]  = tbl[{2'b00, d[1:0]}];
    assign gen[i]   = tbl[{2'b01, d[1:0]}];

    assign carry[i+1] = prop[i] ? carry[i] : gen[i];

    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= lut_f[i];
    end

    assign ffq[i]                    = q;
    assign dout[i]                   = cfg[SEL_OUT] ? q : lut_f[i];
    assign cfg_flat[i*CFG_W +: CFG_W] = cfg;
  end
endmodule

// File: rtl/cluster_chk.sv
module cluster_chk #(
  parameter int N_ELEM = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [N_ELEM-1:0]     cfg_en,
  input logic [17:0]           cfg_word,
  input logic                  cin,
  input logic                  cout,
  input logic [N_ELEM-1:0]     dout,
  input logic [N_ELEM*18-1:0]  cfg_flat,
  input logic [N_ELEM-1:0]     lut_f,
  input logic [N_ELEM-1:0]     prop,
  input logic [N_ELEM-1:0]     ffq
);
  localparam int CFG_W = 18;

  // R5
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (ffq == '0 && cfg_flat == '0));

  // R7
  chain_prop_chk: assert property (@(posedge clk) disable iff (rst)
    (&prop) |-> (cout == cin));

  for (genvar i = 0; i < N_ELEM; i++) begin : g_chk
    // R6
    cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_en[i] |=> (cfg_flat[i*CFG_W +: CFG_W] == $past(cfg_word)));

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !cfg_en[i] |=> $stable(cfg_flat[i*CFG_W +: CFG_W]));

    // R4
    reg_out_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_flat[i*CFG_W + CFG_W - 1] |=>
        (!cfg_flat[i*CFG_W + CFG_W - 1] || dout[i] == $past(lut_f[i])));
  end
endmodule

bind lut4_adder_cluster cluster_chk #(.N_ELEM(N_ELEM)) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_word(cfg_word),
  .cin(cin), .cout(cout), .dout(dout), .cfg_flat(cfg_flat),
  .lut_f(lut_f), .prop(prop), .ffq(ffq)
);

// File: tb/tb_lut4_adder_cluster.sv
module tb_lut4_adder_cluster;
  localparam int PERIOD = 10;
  localparam int N = 8;
  localparam logic [17:0] ADD_COMB = {1'b0, 1'b1, 16'h9686};
  localparam logic [17:0] ADD_REG  = {1'b1, 1'b1, 16'h9686};

  localparam logic [16:0] VEC [10] = '{
    {8'h00, 8'h00, 1'b0}, {8'h01, 8'h01, 1'b0}, {8'hFF, 8'h01, 1'b0},
    {8'hFF, 8'h00, 1'b1}, {8'h80, 8'h80, 1'b0}, {8'hAA, 8'h55, 1'b0},
    {8'hAA, 8'h55, 1'b1}, {8'h0F, 8'hF0, 1'b1}, {8'h7F, 8'h7F, 1'b1},
    {8'hFF, 8'hFF, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]   cfg_en = '0;
  logic [17:0]    cfg_word = '0;
  logic [4*N-1:0] din = '0;
  logic           cin = 1'b0;
  logic           cout;
  logic [N-1:0]   dout;

  int n_chk = 0;
  int n_fail = 0;

  lut4_adder_cluster #(.N_ELEM(N)) dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_word(cfg_word),
    .din(din), .cin(cin), .cout(cout), .dout(dout)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ops(input logic [7:0] a, input logic [7:0] b, input logic c);
    for (int i = 0; i < N; i++) din[i*4 +: 4] = {1'b1, 1'b0, b[i], a[i]};
    cin = c;
  endtask

  task automatic write_cfg(input logic [N-1:0] en, input logic [17:0] w);
    cfg_en = en;
    cfg_word = w;
    tick();
    cfg_en = '0;
  endtask

  logic [8:0] exp9;
  logic [7:0] prev;

  initial begin
    #(PERIOD*100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R5 reset dout", 32'(dout), 32'h0);
    chk("R5 reset cout", 32'(cout), 32'h0);
    rst = 1'b0;

    write_cfg('1, ADD_COMB);
    for (int k = 0; k < 10; k++) begin
      set_ops(VEC[k][16:9], VEC[k][8:1], VEC[k][0]);
      #1;
      exp9 = {1'b0, VEC[k][16:9]} + {1'b0, VEC[k][8:1]} + 9'(VEC[k][0]);
      chk("R8 table sum", 32'(dout), 32'(exp9[7:0]));
      chk("R3 R7 table carry", 32'(cout), 32'(exp9[8]));
    end

    for (int k = 0; k < 20; k++) begin
      logic [7:0] a, b;
      logic c;
      a = 8'($urandom); b = 8'($urandom); c = 1'($urandom);
      set_ops(a, b, c);
      #1;
      exp9 = {1'b0, a} + {1'b0, b} + 9'(c);
      chk("R8 random sum", 32'(dout), 32'(exp9[7:0]));
      chk("R2 R3 random carry", 32'(cout), 32'(exp9[8]));
    end

    write_cfg('1, ADD_REG);
    prev = dout;
    for (int k = 0; k < 10; k++) begin
      logic [7:0] a, b;
      logic c;
      a = 8'($urandom); b = 8'($urandom); c = 1'($urandom);
      set_ops(a, b, c);
      #1;
      exp9 = {1'b0, a} + {1'b0, b} + 9'(c);
      chk("R4 hold before edge", 32'(dout), 32'(prev));
      chk("R3 registered carry", 32'(cout), 32'(exp9[8]));
      tick();
      chk("R4 registered sum", 32'(dout), 32'(exp9[7:0]));
      prev = dout;
    end

    rst = 1'b1;
    tick();
    chk("R5 reset ff", 32'(dout), 32'h0);
    rst = 1'b0;
    set_ops(8'h03, 8'h05, 1'b0);
    #1;
    chk("R5 config cleared", 32'(dout), 32'h0);
    chk("R5 config cleared carry", 32'(cout), 32'h0);

    write_cfg('1, ADD_COMB);
    set_ops(8'h0F, 8'h01, 1'b0);
    #1;
    chk("R8 sum before hold", 32'(dout), 32'h10);
    write_cfg('0, 18'h0);
    chk("R6 no write without enable", 32'(dout), 32'h10);

    write_cfg(8'h01, {1'b0, 1'b0, 16'hF0F0});
    chk("R6 R7 other elements kept", 32'(dout[7:1]), 32'((8'h07 + 8'h00 + 8'h01) & 8'h7F));
    chk("R3 generate forced carry", 32'(cout), 32'h0);

    din[3:0] = 4'b1100; cin = 1'b0; #1;
    chk("R2 din2 source high", 32'(dout[0]), 32'h1);
    din[3:0] = 4'b1000; cin = 1'b1; #1;
    chk("R2 din2 source low", 32'(dout[0]), 32'h0);
    write_cfg(8'h01, {1'b0, 1'b1, 16'hF0F0});
    din[3:0] = 4'b1000; cin = 1'b1; #1;
    chk("R2 carry source high", 32'(dout[0]), 32'h1);
    din[3:0] = 4'b1100; cin = 1'b0; #1;
    chk("R2 carry source low", 32'(dout[0]), 32'h0);

    write_cfg(8'h01, {1'b0, 1'b0, 16'h0400});
    for (int v = 0; v < 16; v++) begin
      din[3:0] = 4'(v);
      #1;
      chk("R1 index map", 32'(dout[0]), 32'(v == 10));
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule